// File: doc/BRIEF.md
# Per-Bank DRAM Strobe Sequencer

This block turns CPU memory cycles and refresh requests into the row strobe, column strobe and ready pulse that drive an array of DRAM banks. Every bank has its own timing byte, which gives three parameters. The first is the number of wait states between the column strobe and ready. The second is the minimum time the row strobe must stay high before it may fall again. The third is the length of the row strobe during a row-only refresh. All times are counted in cycles of the double-rate CPU clock that clocks the block.

A CPU cycle is a level request with a bank number and a read/write flag. The requester holds it until it sees a one-cycle ready, and then drops it. A refresh request is a one-cycle pulse with a bank number. The block keeps it pending until the refresh can run. When a refresh and an access compete, the refresh runs first. The row/column select output tells the address multiplexer which half of the address to present.

Top module: `dram_bank_timer`

## Requirements
- R1: After a synchronous reset, every row strobe and the column strobe are high, ready is low, the write strobe is high and row/column select is 1 (row).
- R2: An access drops the selected bank's row strobe with select = 1 for one cycle. In the next cycle it drops the column strobe and sets select to 0 (column).
- R3: Ready rises N cycles after the column strobe falls. N comes from bits 7:6 of the bank's timing byte: 00 → 3, 01 → 4, 10 → 5, and 11 is treated as 5.
- R4: Ready is high for exactly one cycle. In the cycle after it, the row strobe and column strobe are high again and select returns to 1.
- R5: After a bank's row strobe rises, at the end of an access or of a refresh, the strobe stays high for at least P cycles before it falls again. P comes from bits 4:3 of that bank's byte: 00 → 4, 01 → 6, 10 → 8, 11 → 8. A request that waits only on this limit starts exactly P cycles after the rise.
- R6: A refresh drops only the addressed bank's row strobe, for W cycles. W comes from bits 2:1 of that bank's byte: 00 → 4, 01 → 5, 10 → 6, 11 → 7. The column strobe stays high and ready stays low.
- R7: Only the bank named by a request has its row strobe driven low. Its timing comes from its own byte only; bits [8b+7:8b] of the configuration bus belong to bank b.
- R8: When an access and a refresh are both presented to an idle block in the same cycle, the refresh runs first and the access starts after it completes.
- R9: Bits 5 and 0 of each timing byte have no effect on any timing.
- R10: The write strobe is low from the row strobe's fall to its rise in write accesses. It stays high in reads and refreshes.
- R11: A refresh requested while an access is in progress is kept. It starts on the second cycle after the access's ready pulse, when the bank is already precharged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate CPU clock; all timing counts its cycles |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU cycle request, held until ready |
| req_bank | input | BW | Bank addressed by the CPU cycle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| rfsh_req | input | 1 | One-cycle refresh request pulse |
| rfsh_bank | input | BW | Bank to refresh |
| timing_cfg | input | NBANK*8 | Timing bytes, byte b for bank b |
| ras_n | output | NBANK | Active-low row strobes, one per bank |
| cas_n | output | 1 | Active-low column strobe |
| row_sel | output | 1 | Address multiplexer select: 1 row, 0 column |
| we_n | output | 1 | Active-low write strobe |
| rdy | output | 1 | One-cycle ready to the CPU |

## Verification
A wrong wait-state counter shows as a ready pulse that is early or late by a whole cycle, within at most five cycles of the column strobe falling. A precharge counter left in the wrong state shows as a wrong gap between the release of a bank and its next row strobe, and the bench measures that gap exactly with back-to-back accesses. A lost or misplaced pending refresh shows either as no row strobe on the refreshed bank within two cycles of the access ending, or as the access strobe appearing before the refresh strobe.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  localparam int CNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_CAS,
    ST_DONE,
    ST_RFSH
  } dbt_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] ws;   // wait states after CAS
    logic [CNT_W-1:0] trp;  // RAS high time
    logic [CNT_W-1:0] pw;   // refresh RAS low time
  } dbt_timing_t;

  function automatic logic [CNT_W-1:0] ws_of(input logic [1:0] code);
    case (code)
      2'b00:   return CNT_W'(3);
      2'b01:   return CNT_W'(4);
      default: return CNT_W'(5);  // 10 and reserved 11
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] trp_of(input logic [1:0] code);
    case (code)
      2'b00:   return CNT_W'(4);
      2'b01:   return CNT_W'(6);
      default: return CNT_W'(8);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] pw_of(input logic [1:0] code);
    return CNT_W'(4) + CNT_W'(code);
  endfunction
endpackage

// File: rtl/dbt_decode.sv
module dbt_decode
  import dbt_pkg::*;
(
  input  logic [7:0]  cfg_byte,
  output dbt_timing_t tim
);
  // bits 5 and 0 carry no timing
  logic unused_rsv;
  assign unused_rsv = cfg_byte[5] ^ cfg_byte[0];

  always_comb begin
    tim.ws  = ws_of(cfg_byte[7:6]);
    tim.trp = trp_of(cfg_byte[4:3]);
    tim.pw  = pw_of(cfg_byte[2:1]);
  end
endmodule

// File: rtl/dbt_precharge.sv
module dbt_precharge
  import dbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             release_i,
  input  logic [CNT_W-1:0] trp_i,
  input  logic             start_i,
  output logic             ready_o
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (release_i) begin
      remain <= trp_i - CNT_W'(1);
    end else if (remain != '0) begin
      remain <= remain - CNT_W'(1);
    end
  end

  assign ready_o = (remain == '0);

  // R5: the sequencer never lowers this bank's RAS while its precharge runs
  assert_precharge_kept_R5: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (remain == '0));
endmodule

// File: rtl/dbt_sequencer.sv
module dbt_sequencer
  import dbt_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BW    = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [BW-1:0]           req_bank,
  input  logic                    req_write,
  input  logic                    rfsh_req,
  input  logic [BW-1:0]           rfsh_bank,
  input  dbt_timing_t [NBANK-1:0] tim,
  input  logic [NBANK-1:0]        bank_ready,
  output logic [NBANK-1:0]        start_o,
  output logic [NBANK-1:0]        release_o,
  output logic [NBANK-1:0]        ras_n,
  output logic                    cas_n,
  output logic                    row_sel,
  output logic                    we_n,
  output logic                    rdy
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  dbt_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [BW-1:0]    cur_bank;
  logic             rp_pend;
  logic [BW-1:0]    rp_bank;

  logic          rf_any;
  logic [BW-1:0] rf_bank;
  logic          go_rf, go_acc, rel_rf, rel_now;
  dbt_timing_t   cur_t;

  always_comb begin
    cur_t   = tim[cur_bank];
    rf_any  = rp_pend | rfsh_req;
    rf_bank = rp_pend ? rp_bank : rfsh_bank;
    go_rf   = (state == ST_IDLE) && rf_any && bank_ready[rf_bank];
    go_acc  = (state == ST_IDLE) && !rf_any && req_valid && bank_ready[req_bank];
    rel_rf  = (state == ST_RFSH) && ((cnt + ONE) == cur_t.pw);
    rel_now = (state == ST_DONE) || rel_rf;
    for (int i = 0; i < NBANK; i++) begin
      start_o[i]   = (go_rf  && (rf_bank  == BW'(i))) ||
                     (go_acc && (req_bank == BW'(i)));
      release_o[i] = rel_now && (cur_bank == BW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      cur_bank <= '0;
      rp_pend  <= 1'b0;
      rp_bank  <= '0;
      ras_n    <= '1;
      cas_n    <= 1'b1;
      row_sel  <= 1'b1;
      we_n     <= 1'b1;
      rdy      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (go_rf) begin
            ras_n    <= ~start_o;
            cur_bank <= rf_bank;
            cnt      <= '0;
            state    <= ST_RFSH;
          end else if (go_acc) begin
            ras_n    <= ~start_o;
            cur_bank <= req_bank;
            we_n     <= ~req_write;
            state    <= ST_ROW;
          end
        end
        ST_ROW: begin
          cas_n   <= 1'b0;
          row_sel <= 1'b0;
          cnt     <= '0;
          state   <= ST_CAS;
        end
        ST_CAS: begin
          if ((cnt + ONE) == cur_t.ws) begin
            rdy   <= 1'b1;
            state <= ST_DONE;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        ST_DONE: begin
          rdy     <= 1'b0;
          ras_n   <= '1;
          cas_n   <= 1'b1;
          row_sel <= 1'b1;
          we_n    <= 1'b1;
          state   <= ST_IDLE;
        end
        ST_RFSH: begin
          if (rel_rf) begin
            ras_n <= '1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        default: state <= ST_IDLE;
      endcase

      if (go_rf) begin
        rp_pend <= 1'b0;
      end else if (rfsh_req && !rp_pend) begin
        rp_pend <= 1'b1;
        rp_bank <= rfsh_bank;
      end
    end
  end

  assert_rdy_single_R4: assert property (@(posedge clk) disable iff (rst)
    rdy |=> !rdy);

  assert_rdy_in_cas_R3: assert property (@(posedge clk) disable iff (rst)
    rdy |-> !cas_n);

  assert_strobes_off_after_rdy_R4: assert property (@(posedge clk) disable iff (rst)
    rdy |=> (cas_n && (ras_n == '1)));

  assert_rfsh_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RFSH) |-> (cas_n && !rdy && we_n));
endmodule

// File: rtl/dram_bank_timer.sv
module dram_bank_timer
  import dbt_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BW    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [BW-1:0]      req_bank,
  input  logic               req_write,
  input  logic               rfsh_req,
  input  logic [BW-1:0]      rfsh_bank,
  input  logic [NBANK*8-1:0] timing_cfg,
  output logic [NBANK-1:0]   ras_n,
  output logic               cas_n,
  output logic               row_sel,
  output logic               we_n,
  output logic               rdy
);
  dbt_timing_t [NBANK-1:0] tim;
  logic [NBANK-1:0] bank_ready, start_s, release_s;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dbt_decode u_dec (
      .cfg_byte (timing_cfg[8*b +: 8]),
      .tim      (tim[b])
    );
    dbt_precharge u_pre (
      .clk       (clk),
      .rst       (rst),
      .release_i (release_s[b]),
      .trp_i     (tim[b].trp),
      .start_i   (start_s[b]),
      .ready_o   (bank_ready[b])
    );
  end

  dbt_sequencer #(.NBANK(NBANK), .BW(BW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_bank   (req_bank),
    .req_write  (req_write),
    .rfsh_req   (rfsh_req),
    .rfsh_bank  (rfsh_bank),
    .tim        (tim),
    .bank_ready (bank_ready),
    .start_o    (start_s),
    .release_o  (release_s),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .row_sel    (row_sel),
    .we_n       (we_n),
    .rdy        (rdy)
  );

  assert_one_ras_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ras_n));

  assert_cas_under_ras_R2: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> (ras_n != '1));

  assert_col_sel_with_cas_R2: assert property (@(posedge clk) disable iff (rst)
    !row_sel |-> !cas_n);

  assert_we_under_ras_R10: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (ras_n != '1));
endmodule

// File: tb/tb_dram_bank_timer.sv
module tb_dram_bank_timer;
  localparam int NBANK = 4;
  localparam int BW    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, rfsh_req = 1'b0;
  logic [BW-1:0] req_bank = '0, rfsh_bank = '0;
  logic [NBANK*8-1:0] timing_cfg = {NBANK{8'h80}};
  logic [NBANK-1:0] ras_n;
  logic cas_n, row_sel, we_n, rdy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dram_bank_timer #(.NBANK(NBANK), .BW(BW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
    .req_write(req_write), .rfsh_req(rfsh_req), .rfsh_bank(rfsh_bank),
    .timing_cfg(timing_cfg), .ras_n(ras_n), .cas_n(cas_n),
    .row_sel(row_sel), .we_n(we_n), .rdy(rdy)
  );

  // {bank[2], write, byte[8], wait states[4], precharge[4]}
  localparam int NVEC = 8;
  localparam logic [18:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 8'h00, 4'd3, 4'd4},
    {2'd1, 1'b1, 8'h48, 4'd4, 4'd6},
    {2'd2, 1'b0, 8'h90, 4'd5, 4'd8},
    {2'd3, 1'b1, 8'hD8, 4'd5, 4'd8},
    {2'd0, 1'b1, 8'h21, 4'd3, 4'd4},
    {2'd1, 1'b0, 8'h69, 4'd4, 4'd6},
    {2'd2, 1'b0, 8'h10, 4'd3, 4'd8},
    {2'd3, 1'b1, 8'h88, 4'd5, 4'd6}
  };

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 20000);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_byte(input int b, input logic [7:0] v);
    timing_cfg[8*b +: 8] = v;
  endtask

  // called at a negedge; returns at the negedge where the strobes are released
  task automatic run_access(input int b, input bit wr, input int exp_gap, input int exp_ws);
    int k;
    logic [NBANK-1:0] sel_mask;
    sel_mask = ~(NBANK'(1) << b);
    req_bank = BW'(b); req_write = wr; req_valid = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (ras_n[b] && k < 40);
    if (exp_gap >= 0) chk(k == exp_gap, "R5 request-to-RAS gap", k, exp_gap);
    chk(ras_n == sel_mask, "R7 only selected bank RAS low", int'(ras_n), int'(sel_mask));
    chk(row_sel && cas_n, "R2 row phase before CAS", {row_sel, cas_n}, 3);
    chk(we_n == !wr, "R10 write strobe follows cycle type", we_n, !wr);
    @(negedge clk);
    chk(!cas_n && !row_sel, "R2 CAS and column select one cycle after RAS", {cas_n, row_sel}, 0);
    k = 0;
    while (!rdy && k < 40) begin @(negedge clk); k++; end
    chk(k == exp_ws, "R3 wait states from CAS to ready", k, exp_ws);
    chk(ras_n == sel_mask && we_n == !wr, "R10 strobes held to ready", int'(ras_n), int'(sel_mask));
    req_valid = 1'b0;
    @(negedge clk);
    chk(!rdy && ras_n == '1 && cas_n && row_sel && we_n, "R4 single ready then release",
        {rdy, ras_n, cas_n, row_sel, we_n}, {1'b0, 4'hF, 3'b111});
  endtask

  task automatic run_refresh(input int b, input int exp_pw);
    int k, w;
    bit quiet;
    rfsh_bank = BW'(b); rfsh_req = 1'b1;
    @(negedge clk);
    rfsh_req = 1'b0;
    k = 0;
    while (ras_n[b] && k < 40) begin @(negedge clk); k++; end
    chk(ras_n == ~(NBANK'(1) << b), "R6 refresh hits only its bank", int'(ras_n), int'(~(NBANK'(1) << b)));
    w = 0; quiet = 1'b1;
    while (!ras_n[b] && w < 40) begin
      if (!cas_n || rdy || !we_n) quiet = 1'b0;
      @(negedge clk); w++;
    end
    chk(w == exp_pw, "R6 refresh RAS width", w, exp_pw);
    chk(quiet, "R6 no CAS, write or ready during refresh", quiet, 1);
  endtask

  initial begin
    int k;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(ras_n == '1 && cas_n && row_sel && we_n && !rdy, "R1 reset state",
        {ras_n, cas_n, row_sel, we_n, rdy}, {4'hF, 4'b1110});

    // vector table: two back-to-back accesses per entry
    for (int v = 0; v < NVEC; v++) begin
      int b, ws, trp;
      bit wr;
      b = int'(VEC[v][18:17]); wr = VEC[v][16];
      ws = int'(VEC[v][7:4]); trp = int'(VEC[v][3:0]);
      timing_cfg = {NBANK{8'hD6}};  // other banks differ (R7)
      set_byte(b, VEC[v][15:8]);    // entries 4,5 set reserved bits (R9)
      idle(10);
      run_access(b, wr, 1, ws);
      run_access(b, wr, trp, ws);
    end

    // refresh widths, bits 2:1
    timing_cfg = {NBANK{8'h00}};
    idle(10);
    set_byte(0, 8'h00); run_refresh(0, 4);
    set_byte(1, 8'h02); run_refresh(1, 5);
    set_byte(2, 8'h04); run_refresh(2, 6);
    set_byte(3, 8'h06); run_refresh(3, 7);
    set_byte(0, 8'h27); idle(10); run_refresh(0, 7);  // R9 reserved bits ignored

    // R5: precharge after a refresh, then access on the same bank
    set_byte(1, 8'h0C); idle(10);
    run_refresh(1, 6);
    run_access(1, 1'b0, 6, 3);

    // R8: simultaneous access (bank 0) and refresh (bank 1)
    timing_cfg = {NBANK{8'h00}};
    idle(10);
    req_bank = 2'd0; req_write = 1'b0; req_valid = 1'b1;
    rfsh_bank = 2'd1; rfsh_req = 1'b1;
    @(negedge clk);
    rfsh_req = 1'b0;
    chk(!ras_n[1] && ras_n[0], "R8 refresh wins over access", int'(ras_n), 4'hD);
    k = 0;
    while (!ras_n[1] && k < 40) begin @(negedge clk); k++; end
    chk(k == 4, "R8 refresh completes before access", k, 4);
    run_access(0, 1'b0, -1, 3);

    // R11: refresh arriving mid-access is kept
    idle(10);
    req_bank = 2'd3; req_write = 1'b1; req_valid = 1'b1;
    k = 0;
    while (cas_n && k < 40) begin @(negedge clk); k++; end
    rfsh_bank = 2'd2; rfsh_req = 1'b1;
    @(negedge clk);
    rfsh_req = 1'b0;
    chk(ras_n[2], "R11 no refresh during access", ras_n[2], 1);
    k = 0;
    while (!rdy && k < 40) begin @(negedge clk); k++; end
    req_valid = 1'b0;
    k = 0;
    while (ras_n[2] && k < 20) begin @(negedge clk); k++; end
    chk(k == 2, "R11 pending refresh starts after access", k, 2);
    chk(cas_n && ras_n[3], "R11 access finished before refresh", {cas_n, ras_n[3]}, 3);
    idle(10);

    finish_run();
  end
endmodule